// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine with Dirty-Rectangle Queue

This block draws axis-aligned rectangles into a linear byte-addressed framebuffer. A request either paints a rectangle with a solid colour or moves a rectangle of pixels from one screen position to another. Pixels are one to four bytes wide. A pixel at column x and row y starts at byte `pixel_bytes*x + pixel_bytes*screen_width*y`. The engine reaches memory through a plain byte-wide read port and write port. Read data returns one cycle after the read strobe.

Source and destination of a copy may overlap. The engine picks the order in which it visits rows and bytes so that the result matches a copy taken through a snapshot of the source. Each finished operation records its destination rectangle in a power-of-two ring of dirty rectangles. A display refresh agent drains the ring one entry at a time and sees each entry clipped to the current screen size. When the whole screen is already due for a repaint, the agent can drop every queued entry at once.

Top module: `rect_blit_engine`

## Requirements
- R1: `cfg_bpp_sel` values 0, 1, 2 and 3 select 1, 2, 3 and 4 bytes per pixel. Pixel (x, y) occupies the bytes starting at address bpp*x + bpp*scr_w*y. Byte i of a pixel holds bits 8i+7..8i of its value (little-endian).
- R2: A fill writes the low bpp bytes of `req_color` into every pixel of the rectangle. Every byte outside the rectangle keeps its value.
- R3: A fill of height greater than one produces its second and later rows by reading back its first row. Every read it issues lies inside that first row.
- R4: A copy whose destination row is below its source row walks rows from the last row upward. The memory afterwards equals a copy through a snapshot of the source. Each memory read is followed in the next cycle by the matching write.
- R5: A copy whose destination lies above its source, or on the same row, gives the snapshot result. On the same row with the destination to the right, bytes are walked right to left.
- R6: `busy` rises in the cycle after a request is accepted while idle. It stays high until the final write and the enqueue are done. Requests presented while `busy` is high are ignored.
- R7: Every accepted request enqueues its destination rectangle (x, y, w, h) as the last step before `busy` falls. A request with zero width or height performs no memory write and is still enqueued.
- R8: The ring holds RING_DEPTH entries (a power of two) and is drained oldest first. Pushing into a full ring drops the oldest entry.
- R9: A `dq_discard` pulse empties the ring, including any entry pushed in the same cycle, so `dq_valid` is low in the next cycle.
- R10: The head entry is shown clipped to the live screen size. x becomes min(x, scr_w), and when x+w exceeds scr_w the width becomes scr_w minus the clipped x. The same rule applies to y and h with scr_h.
- R11: After reset the engine is idle with an empty ring and no memory strobe asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_copy | input | 1 | 1 = copy, 0 = fill |
| req_src_x | input | 12 | Copy source column |
| req_src_y | input | 12 | Copy source row |
| req_dst_x | input | 12 | Destination column |
| req_dst_y | input | 12 | Destination row |
| req_w | input | 12 | Width in pixels |
| req_h | input | 12 | Height in rows |
| req_color | input | 32 | Fill colour, low bytes used |
| cfg_bpp_sel | input | 2 | Bytes per pixel minus one |
| cfg_scr_w | input | 12 | Screen width in pixels |
| cfg_scr_h | input | 12 | Screen height in rows |
| busy | output | 1 | Operation in progress |
| mem_rd_en | output | 1 | Byte read strobe |
| mem_rd_addr | output | AW | Byte read address |
| mem_rd_data | input | 8 | Read data, one cycle after strobe |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_wr_addr | output | AW | Byte write address |
| mem_wr_data | output | 8 | Byte write data |
| dq_pop | input | 1 | Remove the head entry |
| dq_discard | input | 1 | Drop all queued entries |
| dq_valid | output | 1 | Ring not empty |
| dq_x | output | 12 | Clipped head column |
| dq_y | output | 12 | Clipped head row |
| dq_w | output | 12 | Clipped head width |
| dq_h | output | 12 | Clipped head height |

## Verification
Fills are swept over all four pixel widths. The sweep uses a rectangle in the screen interior, a full-width single row, a rectangle touching the bottom-right corner, and a zero-width request. Together these separate lane selection errors, row-replication errors and stray writes. Copies are tried in five placements for every pixel width: destination below with overlap, destination above with overlap, same row shifted right, same row shifted left, and disjoint. Only the correct choice of row order and byte order gives the snapshot result in every overlapping placement. The queue is tested for overflow, discard, busy-time request rejection and clipping against a screen shrunk after enqueue.

// File: rtl/blit_pkg.sv
package blit_pkg;
    localparam int BLIT_CW = 12;
    localparam int COLOR_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_RD,
        ST_WR,
        ST_ENQ
    } blit_st_e;

    typedef struct packed {
        logic [BLIT_CW-1:0] x;
        logic [BLIT_CW-1:0] y;
        logic [BLIT_CW-1:0] w;
        logic [BLIT_CW-1:0] h;
    } rect_t;
endpackage

// File: rtl/blit_addr_gen.sv
module blit_addr_gen #(
    parameter int AW  = 24,
    parameter int CW  = 12,
    parameter int RBW = 15
) (
    input  logic [2:0]     bypp,
    input  logic [AW-1:0]  pitch,
    input  logic [CW-1:0]  px,
    input  logic [CW-1:0]  row,
    input  logic [RBW-1:0] col,
    output logic [AW-1:0]  addr
);
    // byte address = bytes-per-pixel * column + pitch * row + byte offset in row
    assign addr = AW'(bypp) * AW'(px) + pitch * AW'(row) + AW'(col);
endmodule

// File: rtl/blit_dirty_ring.sv
module blit_dirty_ring
    import blit_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  rect_t              push_rect,
    input  logic               pop,
    input  logic               discard,
    input  logic [BLIT_CW-1:0] lim_w,
    input  logic [BLIT_CW-1:0] lim_h,
    output logic               valid,
    output rect_t              head
);
    localparam int LD   = $clog2(DEPTH);
    localparam int CNTW = LD + 1;

    typedef struct packed {
        logic [LD-1:0]   wr;
        logic [LD-1:0]   rd;
        logic [CNTW-1:0] cnt;
    } ring_t;

    ring_t q, d;
    rect_t slot_q [DEPTH];
    rect_t raw;

    logic pop_eff, full, drop;

    always_comb begin
        d       = q;
        pop_eff = pop && (q.cnt != '0);
        full    = (q.cnt == CNTW'(DEPTH));
        drop    = push && full && !pop_eff;
        // pointers wrap by their width, which masks with DEPTH-1
        d.wr    = q.wr + LD'(push);
        d.rd    = q.rd + LD'(pop_eff) + LD'(drop);
        d.cnt   = q.cnt + CNTW'(push) - CNTW'(pop_eff) - CNTW'(drop);
        if (discard) begin
            d.rd  = d.wr;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[q.wr] <= push_rect;
    end

    assign valid = (q.cnt != '0);
    assign raw   = slot_q[q.rd];

    // clip the head against the live screen size
    logic [BLIT_CW:0] x_end, y_end;
    logic [BLIT_CW-1:0] xc, yc;
    always_comb begin
        x_end  = {1'b0, raw.x} + {1'b0, raw.w};
        y_end  = {1'b0, raw.y} + {1'b0, raw.h};
        xc     = (raw.x > lim_w) ? lim_w : raw.x;
        yc     = (raw.y > lim_h) ? lim_h : raw.y;
        head.x = xc;
        head.y = yc;
        head.w = (x_end > {1'b0, lim_w}) ? (lim_w - xc) : raw.w;
        head.h = (y_end > {1'b0, lim_h}) ? (lim_h - yc) : raw.h;
    end
endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
    import blit_pkg::*;
#(
    parameter int AW         = 24,
    parameter int RING_DEPTH = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_copy,
    input  logic [BLIT_CW-1:0]  req_src_x,
    input  logic [BLIT_CW-1:0]  req_src_y,
    input  logic [BLIT_CW-1:0]  req_dst_x,
    input  logic [BLIT_CW-1:0]  req_dst_y,
    input  logic [BLIT_CW-1:0]  req_w,
    input  logic [BLIT_CW-1:0]  req_h,
    input  logic [COLOR_W-1:0]  req_color,
    input  logic [1:0]          cfg_bpp_sel,
    input  logic [BLIT_CW-1:0]  cfg_scr_w,
    input  logic [BLIT_CW-1:0]  cfg_scr_h,
    output logic                busy,
    output logic                mem_rd_en,
    output logic [AW-1:0]       mem_rd_addr,
    input  logic [7:0]          mem_rd_data,
    output logic                mem_wr_en,
    output logic [AW-1:0]       mem_wr_addr,
    output logic [7:0]          mem_wr_data,
    input  logic                dq_pop,
    input  logic                dq_discard,
    output logic                dq_valid,
    output logic [BLIT_CW-1:0]  dq_x,
    output logic [BLIT_CW-1:0]  dq_y,
    output logic [BLIT_CW-1:0]  dq_w,
    output logic [BLIT_CW-1:0]  dq_h
);
    localparam int CW  = BLIT_CW;
    localparam int RBW = CW + 3;

    typedef struct packed {
        blit_st_e            st;
        logic [CW-1:0]       sx;
        logic [CW-1:0]       sy;
        logic [CW-1:0]       dx;
        logic [CW-1:0]       dy;
        logic [CW-1:0]       w;
        logic [CW-1:0]       h;
        logic [CW-1:0]       scrw;
        logic [CW-1:0]       roff;
        logic [RBW-1:0]      col;
        logic [COLOR_W-1:0]  color;
        logic [2:0]          bypp;
        logic [1:0]          lane;
        logic                up;
        logic                rev;
        logic                rep;
    } eng_t;

    eng_t q, d;

    logic [2:0]     req_bypp;
    logic [RBW-1:0] req_rowbytes, rowbytes, col_first, col_next;
    logic [CW-1:0]  roff_next, src_row, dst_row;
    logic [AW-1:0]  pitch, src_addr, dst_addr;
    logic           col_end, row_end, push;
    rect_t          push_rect, head;

    assign req_bypp     = {1'b0, cfg_bpp_sel} + 3'd1;
    assign req_rowbytes = RBW'(req_bypp) * RBW'(req_w);
    assign rowbytes     = RBW'(q.bypp) * RBW'(q.w);
    assign pitch        = AW'(q.bypp) * AW'(q.scrw);
    assign col_first    = q.rev ? (rowbytes - RBW'(1)) : '0;
    assign col_next     = q.rev ? (q.col - RBW'(1)) : (q.col + RBW'(1));
    assign col_end      = q.rev ? (q.col == '0) : (q.col == rowbytes - RBW'(1));
    assign row_end      = q.up ? (q.roff == '0) : (q.roff == q.h - CW'(1));
    assign roff_next    = q.up ? (q.roff - CW'(1)) : (q.roff + CW'(1));
    // during fill replication the source is always the first row
    assign src_row      = q.sy + (q.rep ? '0 : q.roff);
    assign dst_row      = q.dy + q.roff;

    blit_addr_gen #(.AW(AW), .CW(CW), .RBW(RBW)) u_src_addr (
        .bypp  (q.bypp),
        .pitch (pitch),
        .px    (q.sx),
        .row   (src_row),
        .col   (q.col),
        .addr  (src_addr)
    );

    blit_addr_gen #(.AW(AW), .CW(CW), .RBW(RBW)) u_dst_addr (
        .bypp  (q.bypp),
        .pitch (pitch),
        .px    (q.dx),
        .row   (dst_row),
        .col   (q.col),
        .addr  (dst_addr)
    );

    always_comb begin
        d           = q;
        mem_rd_en   = 1'b0;
        mem_wr_en   = 1'b0;
        mem_rd_addr = src_addr;
        mem_wr_addr = dst_addr;
        mem_wr_data = mem_rd_data;
        push        = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.sx    = req_src_x;
                    d.sy    = req_src_y;
                    d.dx    = req_dst_x;
                    d.dy    = req_dst_y;
                    d.w     = req_w;
                    d.h     = req_h;
                    d.color = req_color;
                    d.bypp  = req_bypp;
                    d.scrw  = cfg_scr_w;
                    d.lane  = '0;
                    d.rep   = 1'b0;
                    d.up    = req_copy && (req_dst_y > req_src_y);
                    d.rev   = req_copy && (req_dst_y == req_src_y) && (req_dst_x > req_src_x);
                    d.roff  = d.up ? (req_h - CW'(1)) : '0;
                    d.col   = d.rev ? (req_rowbytes - RBW'(1)) : '0;
                    if (req_w == '0 || req_h == '0) d.st = ST_ENQ;
                    else if (req_copy)              d.st = ST_RD;
                    else                            d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_wr_en   = 1'b1;
                mem_wr_data = q.color[{q.lane, 3'b000} +: 8];
                d.lane      = (q.lane == q.bypp[1:0] - 2'd1) ? 2'd0 : q.lane + 2'd1;
                if (col_end) begin
                    if (q.h == CW'(1)) begin
                        d.st = ST_ENQ;
                    end else begin
                        d.rep  = 1'b1;
                        d.sx   = q.dx;
                        d.sy   = q.dy;
                        d.roff = CW'(1);
                        d.col  = '0;
                        d.st   = ST_RD;
                    end
                end else begin
                    d.col = q.col + RBW'(1);
                end
            end
            ST_RD: begin
                mem_rd_en = 1'b1;
                d.st      = ST_WR;
            end
            ST_WR: begin
                mem_wr_en = 1'b1;
                if (col_end) begin
                    if (row_end) begin
                        d.st = ST_ENQ;
                    end else begin
                        d.roff = roff_next;
                        d.col  = col_first;
                        d.st   = ST_RD;
                    end
                end else begin
                    d.col = col_next;
                    d.st  = ST_RD;
                end
            end
            ST_ENQ: begin
                push = 1'b1;
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy        = (q.st != ST_IDLE);
    assign push_rect.x = q.dx;
    assign push_rect.y = q.dy;
    assign push_rect.w = q.w;
    assign push_rect.h = q.h;

    blit_dirty_ring #(.DEPTH(RING_DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_rect (push_rect),
        .pop       (dq_pop),
        .discard   (dq_discard),
        .lim_w     (cfg_scr_w),
        .lim_h     (cfg_scr_h),
        .valid     (dq_valid),
        .head      (head)
    );

    assign dq_x = head.x;
    assign dq_y = head.y;
    assign dq_w = head.w;
    assign dq_h = head.h;
endmodule

// File: rtl/rect_blit_engine_chk.sv
module rect_blit_engine_chk
    import blit_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               busy,
    input logic               mem_rd_en,
    input logic               mem_wr_en,
    input logic               dq_valid,
    input logic               dq_discard,
    input logic [BLIT_CW-1:0] dq_x,
    input logic [BLIT_CW-1:0] dq_y,
    input logic [BLIT_CW-1:0] dq_w,
    input logic [BLIT_CW-1:0] dq_h,
    input logic [BLIT_CW-1:0] cfg_scr_w,
    input logic [BLIT_CW-1:0] cfg_scr_h
);
    a_r6_busy_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !mem_wr_en));

    a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> mem_wr_en);

    a_r4_ports_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    a_r7_done_enqueues: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(dq_discard)) |-> dq_valid);

    a_r9_discard_empties: assert property (@(posedge clk) disable iff (!rst_n)
        dq_discard |=> !dq_valid);

    a_r10_clip_x: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> (({1'b0, dq_x} + {1'b0, dq_w}) <= {1'b0, cfg_scr_w}));

    a_r10_clip_y: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> (({1'b0, dq_y} + {1'b0, dq_h}) <= {1'b0, cfg_scr_h}));
endmodule

bind rect_blit_engine rect_blit_engine_chk u_chk (.*);

// File: tb/rect_blit_engine_test.sv
`timescale 1ns/1ps
module rect_blit_engine_test;
    import blit_pkg::*;
    localparam int CW = BLIT_CW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n, req_valid, req_copy, busy;
    logic [CW-1:0] req_src_x, req_src_y, req_dst_x, req_dst_y, req_w, req_h;
    logic [31:0]   req_color;
    logic [1:0]    cfg_bpp_sel;
    logic [CW-1:0] cfg_scr_w, cfg_scr_h;
    logic          mem_rd_en, mem_wr_en;
    logic [15:0]   mem_rd_addr, mem_wr_addr;
    logic [7:0]    mem_rd_data, mem_wr_data;
    logic          dq_pop, dq_discard, dq_valid;
    logic [CW-1:0] dq_x, dq_y, dq_w, dq_h;

    rect_blit_engine #(.AW(16), .RING_DEPTH(8)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_copy(req_copy),
        .req_src_x(req_src_x), .req_src_y(req_src_y), .req_dst_x(req_dst_x),
        .req_dst_y(req_dst_y), .req_w(req_w), .req_h(req_h), .req_color(req_color),
        .cfg_bpp_sel(cfg_bpp_sel), .cfg_scr_w(cfg_scr_w), .cfg_scr_h(cfg_scr_h),
        .busy(busy), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .dq_pop(dq_pop), .dq_discard(dq_discard),
        .dq_valid(dq_valid), .dq_x(dq_x), .dq_y(dq_y), .dq_w(dq_w), .dq_h(dq_h)
    );

    bit [7:0] mem  [512];
    bit [7:0] refm [512];
    logic [7:0] rdq;
    assign mem_rd_data = rdq;

    int n_run = 0, n_fail = 0, wr_seen = 0, bad_rd = 0;
    bit fill_mon = 0;
    int lo_a = 0, hi_a = 0;
    int bp = 1, sw = 8;

    always @(posedge clk) begin
        if (mem_wr_en) begin
            mem[mem_wr_addr[8:0]] <= mem_wr_data;
            wr_seen++;
        end
        if (mem_rd_en) begin
            rdq <= mem[mem_rd_addr[8:0]];
            if (fill_mon && (int'(mem_rd_addr) < lo_a || int'(mem_rd_addr) >= hi_a)) bad_rd++;
        end
    end

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic int addr_of(int x, int y);
        return bp * x + bp * sw * y;
    endfunction

    task automatic ref_fill(int x, int y, int w, int h, logic [31:0] c);
        for (int r = 0; r < h; r++)
            for (int b = 0; b < bp * w; b++)
                refm[addr_of(x, y + r) + b] = 8'(c >> (8 * (b % bp)));
    endtask

    task automatic ref_copy(int sx, int sy, int dx, int dy, int w, int h);
        bit [7:0] tmp [512];
        tmp = refm;
        for (int r = 0; r < h; r++)
            for (int b = 0; b < bp * w; b++)
                refm[addr_of(dx, dy + r) + b] = tmp[addr_of(sx, sy + r) + b];
    endtask

    task automatic issue(bit cp, int sx, int sy, int dx, int dy, int w, int h, logic [31:0] c);
        @(negedge clk);
        req_copy = cp; req_src_x = CW'(sx); req_src_y = CW'(sy);
        req_dst_x = CW'(dx); req_dst_y = CW'(dy); req_w = CW'(w); req_h = CW'(h);
        req_color = c; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic run(bit cp, int sx, int sy, int dx, int dy, int w, int h, logic [31:0] c);
        fill_mon = !cp;
        lo_a = addr_of(dx, dy);
        hi_a = lo_a + bp * w;
        issue(cp, sx, sy, dx, dy, w, h, c);
        wait_idle();
        fill_mon = 0;
        if (cp) ref_copy(sx, sy, dx, dy, w, h);
        else    ref_fill(dx, dy, w, h, c);
    endtask

    task automatic check_mem(string rq);
        int bad = 0;
        for (int i = 0; i < 512; i++) if (mem[i] != refm[i]) bad++;
        chk(bad == 0, rq, "bytes differing from model", bad, 0);
    endtask

    task automatic pop_chk(string rq, int x, int y, int w, int h);
        longint act, exp;
        @(negedge clk);
        chk(dq_valid == 1'b1, rq, "queue entry present", longint'(dq_valid), 1);
        act = (longint'(dq_x) << 36) | (longint'(dq_y) << 24) | (longint'(dq_w) << 12) | longint'(dq_h);
        exp = (longint'(x) << 36) | (longint'(y) << 24) | (longint'(w) << 12) | longint'(h);
        chk(act == exp, rq, "packed rect x|y|w|h", act, exp);
        dq_pop = 1'b1;
        @(negedge clk);
        dq_pop = 1'b0;
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        report();
    end

    initial begin
        int fx[3] = '{1, 0, 5};
        int fy[3] = '{1, 0, 6};
        int fw[3] = '{3, 8, 3};
        int fh[3] = '{2, 1, 2};
        int csx[5] = '{1, 2, 1, 3, 0};
        int csy[5] = '{1, 3, 2, 2, 0};
        int cdx[5] = '{2, 1, 3, 1, 4};
        int cdy[5] = '{3, 1, 2, 2, 5};
        int cw[5]  = '{3, 3, 4, 4, 3};
        int ch[5]  = '{3, 3, 2, 2, 2};
        int ws;
        rst_n = 0; req_valid = 0; req_copy = 0; req_color = '0;
        req_src_x = '0; req_src_y = '0; req_dst_x = '0; req_dst_y = '0; req_w = '0; req_h = '0;
        cfg_bpp_sel = 2'd0; cfg_scr_w = CW'(8); cfg_scr_h = CW'(8);
        dq_pop = 0; dq_discard = 0;
        for (int i = 0; i < 512; i++) begin
            mem[i]  = 8'(i * 7 + 3);
            refm[i] = 8'(i * 7 + 3);
        end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0, "R11", "busy after reset", longint'(busy), 0);
        chk(dq_valid == 1'b0, "R11", "queue empty after reset", longint'(dq_valid), 0);
        chk(!mem_rd_en && !mem_wr_en, "R11", "memory strobes", longint'({mem_rd_en, mem_wr_en}), 0);

        for (int sel = 0; sel < 4; sel++) begin
            cfg_bpp_sel = 2'(sel);
            bp = sel + 1;
            // R1: one pixel at the bottom-right corner, little-endian bytes
            run(0, 0, 0, 7, 7, 1, 1, 32'h11223344);
            for (int b = 0; b < bp; b++)
                chk(mem[addr_of(7, 7) + b] == 8'(32'h11223344 >> (8 * b)), "R1",
                    "corner pixel byte", longint'(mem[addr_of(7, 7) + b]),
                    longint'(8'(32'h11223344 >> (8 * b))));
            pop_chk("R7", 7, 7, 1, 1);
            for (int k = 0; k < 3; k++) begin
                bad_rd = 0;
                run(0, 0, 0, fx[k], fy[k], fw[k], fh[k], 32'hA1B2C3D4 ^ (32'h01010101 * (sel * 3 + k)));
                check_mem("R2");
                chk(bad_rd == 0, "R3", "fill reads outside first row", bad_rd, 0);
                pop_chk("R7", fx[k], fy[k], fw[k], fh[k]);
            end
            ws = wr_seen;
            run(0, 0, 0, 2, 2, 0, 3, 32'hFFFFFFFF);
            chk(wr_seen == ws, "R7", "writes for zero-width fill", wr_seen - ws, 0);
            pop_chk("R7", 2, 2, 0, 3);
            for (int k = 0; k < 5; k++) begin
                run(1, csx[k], csy[k], cdx[k], cdy[k], cw[k], ch[k], 32'h0);
                check_mem((k == 0 || k == 4) ? "R4" : "R5");
                pop_chk("R7", cdx[k], cdy[k], cw[k], ch[k]);
            end
        end

        // R6: request while busy is ignored
        cfg_bpp_sel = 2'd0; bp = 1;
        issue(0, 0, 0, 1, 1, 4, 3, 32'h5A);
        chk(busy == 1'b1, "R6", "busy after acceptance", longint'(busy), 1);
        req_copy = 0; req_dst_x = '0; req_dst_y = '0; req_w = CW'(8); req_h = CW'(8);
        req_color = 32'hFF; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        ref_fill(1, 1, 4, 3, 32'h5A);
        check_mem("R6");
        pop_chk("R6", 1, 1, 4, 3);
        @(negedge clk);
        chk(dq_valid == 1'b0, "R6", "extra queue entry", longint'(dq_valid), 0);

        // R8: overflow of an 8-entry ring drops the two oldest
        for (int k = 0; k < 10; k++) run(0, 0, 0, k % 8, k / 8, 1, 1, 32'(k));
        check_mem("R8");
        for (int k = 0; k < 8; k++) pop_chk("R8", (k + 2) % 8, (k + 2) / 8, 1, 1);
        @(negedge clk);
        chk(dq_valid == 1'b0, "R8", "ring empty after draining", longint'(dq_valid), 0);

        // R9: discard
        run(0, 0, 0, 0, 4, 2, 2, 32'h33);
        run(1, 0, 4, 3, 4, 2, 2, 32'h0);
        @(negedge clk);
        dq_discard = 1'b1;
        @(negedge clk);
        dq_discard = 1'b0;
        chk(dq_valid == 1'b0, "R9", "queue after discard", longint'(dq_valid), 0);
        run(0, 0, 0, 6, 0, 2, 1, 32'h44);
        check_mem("R9");
        pop_chk("R9", 6, 0, 2, 1);
        @(negedge clk);
        chk(dq_valid == 1'b0, "R9", "single entry after refill", longint'(dq_valid), 0);

        // R10: clip against a screen shrunk after enqueue
        run(0, 0, 0, 2, 3, 5, 4, 32'h66);
        run(0, 0, 0, 6, 1, 2, 2, 32'h77);
        @(negedge clk);
        cfg_scr_w = CW'(4); cfg_scr_h = CW'(5);
        pop_chk("R10", 2, 3, 2, 2);
        pop_chk("R10", 4, 1, 0, 2);
        cfg_scr_w = CW'(8); cfg_scr_h = CW'(8);
        check_mem("R10");

        report();
    end
endmodule